// File: doc/BRIEF.md
# Serial Port Interrupt and Status Controller

This block gathers the event indications of a serial port's transmit and receive paths, keeps them in a small register set, and combines them into one interrupt request. Rising edges on the receive-level, transmit-level, receive-timeout and error indications set sticky event flags. Software clears a flag by writing 0 to its position. A write of 1 leaves the flag alone, so a read-modify-write that clears one flag cannot erase another.

A second, 6-bit change register records modem and line conditions. Three of its bits are latched events and three follow live inputs. The change register has its own enable mask in the control register, and the masked OR of the change register appears as a summary bit in the status register. The interrupt line is the OR of every latched event gated by its enable, plus that summary bit.

Access is through a simple word port. On `wr_addr` and `rd_addr`, 0 selects control, 1 selects status, 2 selects change, and 3 reads as zero. Reads are combinational from `rd_addr`. A write takes effect at the clock edge where `wr_en` is high.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset, the control register reads 0, all latched event flags (status bits 10:7 and change bits 5, 3, 0) read 0, and `irq` is low.
- R2: Control bits 15 (transmit DMA enable), 14 (receive DMA enable), 13 (transmit interrupt enable), 12 (receive interrupt enable), 11 (error interrupt enable) and 5:0 (change mask) are writable. The other bits always read 0, so writing 0xFFFF reads back 0xF83F.
- R3: A rising edge sets a status flag: `rx_lvl_hit` sets bit 7, `tx_lvl_hit` sets bit 8, `rx_tout_hit` sets bit 9, and any of the four error flags going high sets bit 10. A source that stays high sets its flag only once.
- R4: Writing 0 to a status bit in 10:7 clears that flag, and writing 1 leaves it unchanged.
- R5: If a flag's set edge and a clearing write happen in the same cycle, the flag ends up set.
- R6: These status bits follow their inputs directly: bit 15 break, bit 14 receive-empty, bit 13 framing error, bit 12 parity error, bit 11 overrun and bits 4:0 receive count. Bit 5 reads 0.
- R7: Change bit 4 reads 1 while `cts_active` is low. Bit 2 follows `tx_ready` and bit 1 follows `tx_all_sent`.
- R8: Change bit 5 sets on a rising edge of overrun, and bit 3 on a rising edge of `line_brk`. Bit 0 sets on either edge of `line_brk`. Writing 0 clears each of these bits and writing 1 keeps it.
- R9: Status bit 6 is the OR of (change register AND control bits 5:0).
- R10: `irq` is high when any of these holds:
  - bit 8 is set with bit 13 enabled;
  - bit 7 or bit 9 is set with bit 12 enabled;
  - bit 10 is set with bit 11 enabled;
  - status bit 6 is high.
- R11: One cycle after a write of 0 to the control register, `irq` is low whatever flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write select: 0 control, 1 status, 2 change |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read select, same encoding |
| rd_data | output | 16 | Read data of the selected register |
| rx_lvl_hit | input | 1 | Receive level reached |
| tx_lvl_hit | input | 1 | Transmit level reached |
| rx_tout_hit | input | 1 | Receive timeout |
| rx_brk_flag | input | 1 | Break on current character |
| rx_fer_flag | input | 1 | Framing error on current character |
| rx_per_flag | input | 1 | Parity error on current character |
| rx_ovr_flag | input | 1 | Receive overrun |
| rx_empty | input | 1 | Receive buffer holds no valid data |
| rx_count | input | 5 | Receive buffer fill count |
| cts_active | input | 1 | Clear-to-send asserted |
| line_brk | input | 1 | Break condition on the receive line |
| tx_ready | input | 1 | Transmitter ready |
| tx_all_sent | input | 1 | Transmitter fully drained |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle:
- a set edge always leaves its flag set one cycle later;
- a clearing write with no set edge empties the status flags;
- flags hold still without a set or a write;
- an all-zero control register keeps `irq` low;
- the CTS bit mirrors the input inversely.

Only the bench scenarios show the rest: edge rather than level sensitivity, the both-edge behaviour of the break-change bit, the live field positions, and which enable gates which flag in `irq`.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int DATA_W  = 16;
  localparam int RCNT_W  = 5;
  localparam int EVT_N   = 4;   // status flags, bits 10:7
  localparam int CHG_N   = 6;
  localparam int CLAT_N  = 3;   // latched change bits 5,3,0

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_CHG  = 2'd2,
    A_NONE = 2'd3
  } reg_sel_e;

  // control bit positions
  localparam int C_TXDMA = 15;
  localparam int C_RXDMA = 14;
  localparam int C_TIE   = 13;
  localparam int C_RIE   = 12;
  localparam int C_SPIE  = 11;
  localparam logic [DATA_W-1:0] CTRL_WMASK = 16'hF83F;

  // status flag base; flag index 0..3 = rdis, tdis, tout, eri
  localparam int S_EVT_LO = 7;
  localparam int S_SUM    = 6;

  function automatic logic chg_summary(input logic [CHG_N-1:0] chg,
                                       input logic [CHG_N-1:0] mask);
    return |(chg & mask);
  endfunction

  function automatic logic irq_combine(input logic [DATA_W-1:0] ctrl,
                                       input logic [EVT_N-1:0] evt,
                                       input logic sum);
    return (evt[1] & ctrl[C_TIE]) |
           ((evt[0] | evt[2]) & ctrl[C_RIE]) |
           (evt[3] & ctrl[C_SPIE]) |
           sum;
  endfunction
endpackage

// File: rtl/sio_edge_det.sv
module sio_edge_det #(
  parameter int W = 1,
  parameter logic [W-1:0] ANY_EDGE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] pulse
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (ANY_EDGE[i]) begin : g_any
      assign pulse[i] = src[i] ^ prev_q[i];
    end else begin : g_rise
      assign pulse[i] = src[i] & ~prev_q[i];
    end
  end
endmodule

// File: rtl/sio_flag_bank.sv
module sio_flag_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         wr,
  input  logic [W-1:0] keep,
  output logic [W-1:0] q
);
  logic [W-1:0] hold;

  assign hold = wr ? keep : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= set | (q & hold);
  end
endmodule

// File: rtl/sio_ctrl_reg.sv
module sio_ctrl_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= d & WMASK;
  end
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_lvl_hit,
  input  logic              tx_lvl_hit,
  input  logic              rx_tout_hit,
  input  logic              rx_brk_flag,
  input  logic              rx_fer_flag,
  input  logic              rx_per_flag,
  input  logic              rx_ovr_flag,
  input  logic              rx_empty,
  input  logic [RCNT_W-1:0] rx_count,
  input  logic              cts_active,
  input  logic              line_brk,
  input  logic              tx_ready,
  input  logic              tx_all_sent,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q;
  logic [EVT_N-1:0]  evt_src, evt_set, evt_q;
  logic [CLAT_N-1:0] clat_src, chg_set, clat_q;
  logic [CHG_N-1:0]  chg_q;
  logic              err_any, stat_sum;
  logic              wr_ctrl, wr_stat, wr_chg;
  logic [DATA_W-1:0] stat_rd;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign wr_chg  = wr_en && (wr_addr == A_CHG);

  sio_ctrl_reg #(.W(DATA_W), .WMASK(CTRL_WMASK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .d(wr_data), .q(ctrl_q)
  );

  // status events: index 0 rdis, 1 tdis, 2 tout, 3 eri
  assign err_any = rx_brk_flag | rx_fer_flag | rx_per_flag | rx_ovr_flag;
  assign evt_src = {err_any, rx_tout_hit, tx_lvl_hit, rx_lvl_hit};

  sio_edge_det #(.W(EVT_N), .ANY_EDGE('0)) u_evt_edge (
    .clk(clk), .rst_n(rst_n), .src(evt_src), .pulse(evt_set)
  );

  sio_flag_bank #(.W(EVT_N)) u_evt_flags (
    .clk(clk), .rst_n(rst_n), .set(evt_set), .wr(wr_stat),
    .keep(wr_data[S_EVT_LO +: EVT_N]), .q(evt_q)
  );

  // latched change bits: index 2 overrun, 1 break seen, 0 break change
  assign clat_src = {rx_ovr_flag, line_brk, line_brk};

  sio_edge_det #(.W(CLAT_N), .ANY_EDGE(3'b001)) u_chg_edge (
    .clk(clk), .rst_n(rst_n), .src(clat_src), .pulse(chg_set)
  );

  sio_flag_bank #(.W(CLAT_N)) u_chg_flags (
    .clk(clk), .rst_n(rst_n), .set(chg_set), .wr(wr_chg),
    .keep({wr_data[5], wr_data[3], wr_data[0]}), .q(clat_q)
  );

  assign chg_q = {clat_q[2], ~cts_active, clat_q[1], tx_ready, tx_all_sent, clat_q[0]};

  assign stat_sum = chg_summary(chg_q, ctrl_q[CHG_N-1:0]);

  assign stat_rd = {rx_brk_flag, rx_empty, rx_fer_flag, rx_per_flag, rx_ovr_flag,
                    evt_q, stat_sum, 1'b0, rx_count};

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = ctrl_q;
      A_STAT:  rd_data = stat_rd;
      A_CHG:   rd_data = {{(DATA_W-CHG_N){1'b0}}, chg_q};
      default: rd_data = '0;
    endcase
  end

  assign irq = irq_combine(ctrl_q, evt_q, stat_sum);
endmodule

// File: rtl/sio_irq_ctrl_chk.sv
module sio_irq_ctrl_chk
  import sio_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [EVT_N-1:0]  evt_set,
  input logic [EVT_N-1:0]  evt_q,
  input logic [CLAT_N-1:0] chg_set,
  input logic [CLAT_N-1:0] clat_q,
  input logic              cts_active,
  input logic              irq
);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (evt_q == '0 && clat_q == '0 && ctrl_q == '0));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_STAT && wr_data[S_EVT_LO +: EVT_N] == '0 && evt_set == '0)
      |=> (evt_q == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_addr == A_STAT) && evt_set == '0) |=> $stable(evt_q));

  p_chg_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CHG && wr_data[5] == 1'b0 && wr_data[3] == 1'b0 &&
     wr_data[0] == 1'b0 && chg_set == '0) |=> (clat_q == '0));

  p_cts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_CHG) |-> (rd_data[4] == !cts_active));

  p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == '0) |-> !irq);
endmodule

bind sio_irq_ctrl sio_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .ctrl_q(ctrl_q), .evt_set(evt_set),
  .evt_q(evt_q), .chg_set(chg_set), .clat_q(clat_q), .cts_active(cts_active),
  .irq(irq)
);

// File: tb/sio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sio_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic [1:0] rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic rx_lvl_hit = 0, tx_lvl_hit = 0, rx_tout_hit = 0;
  logic rx_brk_flag = 0, rx_fer_flag = 0, rx_per_flag = 0, rx_ovr_flag = 0;
  logic rx_empty = 1;
  logic [4:0] rx_count = 5'd0;
  logic cts_active = 0, line_brk = 0, tx_ready = 0, tx_all_sent = 0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rx_lvl_hit(rx_lvl_hit),
    .tx_lvl_hit(tx_lvl_hit), .rx_tout_hit(rx_tout_hit), .rx_brk_flag(rx_brk_flag),
    .rx_fer_flag(rx_fer_flag), .rx_per_flag(rx_per_flag), .rx_ovr_flag(rx_ovr_flag),
    .rx_empty(rx_empty), .rx_count(rx_count), .cts_active(cts_active),
    .line_brk(line_brk), .tx_ready(tx_ready), .tx_all_sent(tx_all_sent), .irq(irq)
  );

  // entry: [12:9] pulse {err,tout,tx,rx}, [8] write, [7:4] data for bits 10:7, [3:0] expected bits 10:7
  localparam logic [12:0] VEC [10] = '{
    {4'b0001, 1'b0, 4'b0000, 4'b0001},
    {4'b0010, 1'b0, 4'b0000, 4'b0011},
    {4'b0000, 1'b1, 4'b1110, 4'b0010},
    {4'b0100, 1'b0, 4'b0000, 4'b0110},
    {4'b1000, 1'b0, 4'b0000, 4'b1110},
    {4'b0000, 1'b1, 4'b0000, 4'b0000},
    {4'b1111, 1'b0, 4'b0000, 4'b1111},
    {4'b0000, 1'b1, 4'b0101, 4'b0101},
    {4'b0000, 1'b1, 4'b1111, 4'b0101},
    {4'b0000, 1'b1, 4'b0000, 4'b0000}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0; wr_data = 16'h0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); chk("R1 status", v, 16'h4000);
    rd(2'd2, v); chk("R1 change", v, 16'h0010);
    chk("R1 irq", {15'h0, irq}, 16'h0);

    // R3/R4 vector walk
    foreach (VEC[i]) begin
      {rx_fer_flag, rx_tout_hit, tx_lvl_hit, rx_lvl_hit} = VEC[i][12:9];
      tick();
      {rx_fer_flag, rx_tout_hit, tx_lvl_hit, rx_lvl_hit} = 4'b0;
      if (VEC[i][8]) wr(2'd1, {5'b0, VEC[i][7:4], 7'b0});
      else tick();
      rd(2'd1, v);
      chk("R3 R4 vector", {12'h0, v[10:7]}, {12'h0, VEC[i][3:0]});
    end

    // R2 control write mask
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R2 ctrl mask", v, 16'hF83F);
    wr(2'd0, 16'h0000);

    // R5 set beats clear; R3 held source sets once
    rx_lvl_hit = 1; tick(); rx_lvl_hit = 0; tick();
    rx_lvl_hit = 1; wr(2'd1, 16'h0000);
    rd(2'd1, v); chk("R5 set wins", {15'h0, v[7]}, 16'h1);
    wr(2'd1, 16'h0000);
    rd(2'd1, v); chk("R3 held source no reset", {15'h0, v[7]}, 16'h0);
    rx_lvl_hit = 0; tick();

    // R6 live status fields
    rx_brk_flag = 1; rx_per_flag = 1; rx_empty = 0; rx_count = 5'h15;
    tick();
    rd(2'd1, v); chk("R6 live fields", v & 16'hF83F, 16'h9015);
    rx_brk_flag = 0; rx_per_flag = 0; rx_empty = 1; rx_count = 5'h0;
    wr(2'd1, 16'h0000);
    rd(2'd1, v); chk("R4 cleared", v, 16'h4000);

    // R7 live change bits
    cts_active = 1; tx_ready = 1; tx_all_sent = 1; tick();
    rd(2'd2, v); chk("R7 cts active", v, 16'h0006);
    cts_active = 0; tx_ready = 0; tick();
    rd(2'd2, v); chk("R7 cts inactive", v, 16'h0012);
    cts_active = 1; tx_all_sent = 0; tick();

    // R8 latched change bits
    line_brk = 1; tick();
    rd(2'd2, v); chk("R8 break rise", v, 16'h0009);
    wr(2'd2, 16'h0000);
    rd(2'd2, v); chk("R8 clear held", v, 16'h0000);
    line_brk = 0; tick();
    rd(2'd2, v); chk("R8 break fall", v, 16'h0001);
    rx_ovr_flag = 1; tick(); rx_ovr_flag = 0; tick();
    rd(2'd2, v); chk("R8 overrun", v, 16'h0021);
    wr(2'd2, 16'h0001);
    rd(2'd2, v); chk("R8 keep on write 1", v, 16'h0001);

    // R9 summary
    wr(2'd0, 16'h0001);
    rd(2'd1, v); chk("R9 summary on", {15'h0, v[6]}, 16'h1);
    chk("R10 summary irq", {15'h0, irq}, 16'h1);
    wr(2'd2, 16'h0000);
    rd(2'd1, v); chk("R9 summary off", {15'h0, v[6]}, 16'h0);
    chk("R10 error not enabled", {15'h0, irq}, 16'h0);
    wr(2'd1, 16'h0000);

    // R10 enable routing
    tx_lvl_hit = 1; tick(); tx_lvl_hit = 0;
    wr(2'd0, 16'h2000);
    chk("R10 tx enable", {15'h0, irq}, 16'h1);
    wr(2'd0, 16'h1000);
    chk("R10 rx enable no tx", {15'h0, irq}, 16'h0);
    rx_tout_hit = 1; tick(); rx_tout_hit = 0; tick();
    chk("R10 timeout via rx enable", {15'h0, irq}, 16'h1);
    wr(2'd0, 16'h0800);
    chk("R10 error enable no error", {15'h0, irq}, 16'h0);
    rx_fer_flag = 1; tick(); rx_fer_flag = 0; tick();
    chk("R10 error irq", {15'h0, irq}, 16'h1);

    // R11 disable all
    wr(2'd0, 16'h0000);
    chk("R11 all off", {15'h0, irq}, 16'h0);

    done = 1;
    summary();
  end
endmodule